// File: doc/BRIEF.md
# Line-Bounded Read Burst Splitter

This block sits between a processor's read request port and the read-address channel of an AXI bus. It takes a request made of a byte address, a byte count and a line-fill flag, and turns it into read-address bursts. None of these bursts ever spans two 64-byte lines. A line-fill request becomes one wrapping burst. That burst fetches the whole line, and its first beat is the word that holds the requested byte, so the critical word arrives first. A plain request becomes incrementing bursts cut at line edges and issued in ascending address order, so a request longer than a line needs several of them.

Both sides use valid/ready. `req_ready` is high only while nothing is outstanding, so a request waits on back-pressure until the previous one has fully drained. On the bus side a presented burst keeps `ar_valid` high, and its fields do not change, until `ar_ready` is seen. Only after that handshake is the next piece put on the bus. A one-cycle `done` pulse reports that the last piece of a request has been handed off. The data bus is 8 bytes wide, so every burst uses a beat size code of 3.

Top module: `line_split_rd`

## Requirements
- R1: `req_ready` is high exactly when no burst of an earlier request is pending, and it is low in every cycle where `ar_valid` is high.
- R2: A fill request with nonzero length issues exactly one burst. That burst has `ar_burst`=2 (wrap), `ar_size`=3, `ar_len`=7, and `ar_addr` equal to the request address with bits [2:0] cleared.
- R3: A plain request that fits inside its line issues exactly one burst. That burst has `ar_burst`=1 (incr), `ar_size`=3, `ar_addr` equal to the request address, and `ar_len` equal to the number of 8-byte words touched minus one.
- R4: A plain request that runs past the end of its line first issues a burst at the request address. This burst covers the words from the start offset up to the line end, so `ar_len` = 7 - addr[5:3].
- R5: The pieces after the first start at consecutive line bases in ascending order, and each piece covers the words still needed in its line, until every byte of the request is covered. The last piece stops at the word that holds the last byte.
- R6: No issued burst crosses a 64-byte boundary: for incrementing bursts, addr[5:3] + `ar_len` is at most 7.
- R7: While `ar_valid` is high and `ar_ready` is low, `ar_valid` stays high and `ar_addr`, `ar_len`, `ar_burst` and `ar_size` hold their values.
- R8: The next piece is presented in the cycle after the previous handshake. `done` is high for exactly the one cycle after the handshake of the final piece, and `ar_valid` is low in that cycle.
- R9: A request with length 0, whether a fill or a plain request, is accepted, raises `done` in the next cycle and issues no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (block idle) |
| req_addr | input | 32 | Byte address of the request |
| req_len | input | 12 | Byte count of the request |
| req_fill | input | 1 | 1 = whole-line wrap fill, 0 = plain read |
| ar_valid | output | 1 | Read-address burst presented |
| ar_ready | input | 1 | Bus takes the burst |
| ar_addr | output | 32 | Burst start address |
| ar_len | output | 8 | Beats minus one |
| ar_size | output | 3 | Beat size code (always 3) |
| ar_burst | output | 2 | 1 = incrementing, 2 = wrapping |
| done | output | 1 | One-cycle pulse after the final piece is taken |

## Verification
The bench sweeps every start offset in a line against lengths placed around the word and line edges: 1, 7, 8, 9, 56, 63, 64, 65, and several multi-line counts. It holds `ar_ready` low for a varying number of cycles on each piece. An off-by-one in the room left in a line would show up as a piece that spills into the next line, or as a missing or extra tail piece. A wrong word count shows up when a byte sits at the start or end of a word. A design that loaded the next piece early, or dropped its fields under stall, would show changed fields while `ar_ready` is low. Zero-length and wrap-fill requests at all 64 offsets check that no burst is issued for an empty request and that the wrap address is cleared to a word boundary.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
  typedef enum logic [1:0] {
    BURST_FIXED = 2'd0,
    BURST_INCR  = 2'd1,
    BURST_WRAP  = 2'd2
  } burst_e;

  localparam int unsigned AR_LEN_W = 8;
endpackage

// File: rtl/lsr_piece_calc.sv
module lsr_piece_calc
  import lsr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned LINE_LG = 6,
  parameter int unsigned BEAT_LG = 3
) (
  input  logic [ADDR_W-1:0]   cur_addr,
  input  logic [LEN_W-1:0]    remain,
  output logic [LEN_W-1:0]    take,
  output logic                last_piece,
  output logic [AR_LEN_W-1:0] beats_m1
);
  localparam int unsigned ROOM_W = LINE_LG + 1;
  localparam int unsigned CMP_W  = (LEN_W > ROOM_W) ? LEN_W : ROOM_W;
  localparam int unsigned IDX_W  = LINE_LG - BEAT_LG;

  logic [LINE_LG-1:0] offset;
  logic [ROOM_W-1:0]  room;
  logic [CMP_W-1:0]   room_x;
  logic [CMP_W-1:0]   remain_x;
  logic [CMP_W-1:0]   take_x;
  logic [ROOM_W-1:0]  end_sum;
  logic [LINE_LG-1:0] end_off;
  logic [IDX_W-1:0]   first_idx;
  logic [IDX_W-1:0]   last_idx;

  always_comb begin
    offset     = cur_addr[LINE_LG-1:0];
    room       = ROOM_W'(1 << LINE_LG) - ROOM_W'(offset);
    room_x     = CMP_W'(room);
    remain_x   = CMP_W'(remain);
    last_piece = (remain_x <= room_x);
    take_x     = last_piece ? remain_x : room_x;
    take       = LEN_W'(take_x);
    end_sum    = ROOM_W'(offset) + ROOM_W'(take_x) - ROOM_W'(1);
    end_off    = end_sum[LINE_LG-1:0];
    first_idx  = offset[LINE_LG-1:BEAT_LG];
    last_idx   = end_off[LINE_LG-1:BEAT_LG];
    beats_m1   = AR_LEN_W'(last_idx - first_idx);
  end
endmodule

// File: rtl/lsr_req_track.sv
module lsr_req_track #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LEN_W   = 12,
  parameter int unsigned LINE_LG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_fill,
  input  logic              ar_fire,
  input  logic [LEN_W-1:0]  take,
  input  logic              last_piece,
  output logic              busy,
  output logic              fill_q,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LEN_W-1:0]  remain,
  output logic              done
);
  logic empty_req;
  logic final_fire;

  always_comb begin
    empty_req  = (req_len == '0);
    final_fire = ar_fire && (fill_q || last_piece);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      fill_q   <= 1'b0;
      cur_addr <= '0;
      remain   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (req_fire) begin
        if (empty_req) begin
          done <= 1'b1;
        end else begin
          busy     <= 1'b1;
          fill_q   <= req_fill;
          cur_addr <= req_addr;
          remain   <= req_len;
        end
      end else if (final_fire) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (ar_fire) begin
        cur_addr <= cur_addr + ADDR_W'(take);
        remain   <= remain - take;
      end
    end
  end

  AST_EMPTY_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && empty_req) |=> (done && !busy)); // R9

  AST_NEXT_AT_LINE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_fire && !fill_q && !last_piece) |=>
      (busy && cur_addr[LINE_LG-1:0] == '0 && cur_addr > $past(cur_addr))); // R5

  AST_DONE_AFTER_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    final_fire |=> (done && !busy)); // R8
endmodule

// File: rtl/lsr_ar_drive.sv
module lsr_ar_drive
  import lsr_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned LINE_LG = 6,
  parameter int unsigned BEAT_LG = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                busy,
  input  logic                fill_q,
  input  logic [ADDR_W-1:0]   cur_addr,
  input  logic [AR_LEN_W-1:0] beats_m1,
  input  logic                ar_ready,
  output logic                ar_valid,
  output logic [ADDR_W-1:0]   ar_addr,
  output logic [AR_LEN_W-1:0] ar_len,
  output logic [2:0]          ar_size,
  output logic [1:0]          ar_burst
);
  localparam int unsigned LINE_BEATS = 1 << (LINE_LG - BEAT_LG);
  localparam int unsigned IDX_W      = LINE_LG - BEAT_LG;

  logic [ADDR_W-1:0] word_addr;

  always_comb begin
    word_addr = {cur_addr[ADDR_W-1:BEAT_LG], {BEAT_LG{1'b0}}};
    ar_valid  = busy;
    ar_size   = 3'(BEAT_LG);
    if (fill_q) begin
      ar_addr  = word_addr;
      ar_len   = AR_LEN_W'(LINE_BEATS - 1);
      ar_burst = BURST_WRAP;
    end else begin
      ar_addr  = cur_addr;
      ar_len   = beats_m1;
      ar_burst = BURST_INCR;
    end
  end

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && !ar_ready) |=>
      (ar_valid && $stable(ar_addr) && $stable(ar_len) && $stable(ar_burst) && $stable(ar_size))); // R7

  AST_INCR_IN_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_burst == BURST_INCR) |->
      ((AR_LEN_W+1)'(ar_addr[LINE_LG-1:BEAT_LG]) + (AR_LEN_W+1)'(ar_len) <= (AR_LEN_W+1)'(LINE_BEATS - 1))); // R6

  AST_WRAP_WHOLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && ar_burst == BURST_WRAP) |->
      (ar_len == AR_LEN_W'(LINE_BEATS - 1) && ar_addr[BEAT_LG-1:0] == '0)); // R2

  AST_SIZE_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> (ar_size == 3'(BEAT_LG) && IDX_W > 0)); // R3
endmodule

// File: rtl/line_split_rd.sv
module line_split_rd
  import lsr_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 12,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned BEAT_BYTES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_fill,
  output logic              ar_valid,
  input  logic              ar_ready,
  output logic [ADDR_W-1:0] ar_addr,
  output logic [7:0]        ar_len,
  output logic [2:0]        ar_size,
  output logic [1:0]        ar_burst,
  output logic              done
);
  localparam int unsigned LINE_LG = $clog2(LINE_BYTES);
  localparam int unsigned BEAT_LG = $clog2(BEAT_BYTES);

  logic              busy;
  logic              fill_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [LEN_W-1:0]  take;
  logic              last_piece;
  logic [AR_LEN_W-1:0] beats_m1;
  logic              req_fire;
  logic              ar_fire;

  always_comb begin
    req_ready = !busy;
    req_fire  = req_valid && req_ready;
    ar_fire   = ar_valid && ar_ready;
  end

  lsr_piece_calc #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_LG(LINE_LG), .BEAT_LG(BEAT_LG)
  ) calc_i (
    .cur_addr(cur_addr), .remain(remain), .take(take),
    .last_piece(last_piece), .beats_m1(beats_m1)
  );

  lsr_req_track #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_LG(LINE_LG)
  ) track_i (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_addr(req_addr),
    .req_len(req_len), .req_fill(req_fill), .ar_fire(ar_fire), .take(take),
    .last_piece(last_piece), .busy(busy), .fill_q(fill_q),
    .cur_addr(cur_addr), .remain(remain), .done(done)
  );

  lsr_ar_drive #(
    .ADDR_W(ADDR_W), .LINE_LG(LINE_LG), .BEAT_LG(BEAT_LG)
  ) drive_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .fill_q(fill_q),
    .cur_addr(cur_addr), .beats_m1(beats_m1), .ar_ready(ar_ready),
    .ar_valid(ar_valid), .ar_addr(ar_addr), .ar_len(ar_len),
    .ar_size(ar_size), .ar_burst(ar_burst)
  );

  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ar_valid |-> !req_ready); // R1

  AST_NEXT_PIECE_PROMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_fire && !done && ar_burst == BURST_INCR && !last_piece) |=> ar_valid); // R8
endmodule

// File: tb/line_split_rd_tb_top.sv
module line_split_rd_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [11:0] req_len = '0;
  logic        req_fill = 1'b0;
  logic        ar_valid;
  logic        ar_ready = 1'b0;
  logic [31:0] ar_addr;
  logic [7:0]  ar_len;
  logic [2:0]  ar_size;
  logic [1:0]  ar_burst;
  logic        done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  line_split_rd dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_fill(req_fill),
    .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
    .ar_len(ar_len), .ar_size(ar_size), .ar_burst(ar_burst), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_fields(input string req, input logic [31:0] ea,
                            input int el, input int eb);
    chk(ar_valid == 1'b1, req, "ar_valid", ar_valid, 1);
    chk(ar_addr == ea, req, "ar_addr", ar_addr, ea);
    chk(int'(ar_len) == el, req, "ar_len", ar_len, el);
    chk(int'(ar_burst) == eb, req, "ar_burst", ar_burst, eb);
    chk(ar_size == 3'd3, req, "ar_size", ar_size, 3);
    chk(req_ready == 1'b0, "R1", "req_ready while busy", req_ready, 0);
  endtask

  task automatic run_req(input logic [31:0] a, input int len, input bit fill);
    logic [31:0] ca = a;
    int r = len;
    int np = 0;
    int total = fill ? (len > 0 ? 1 : 0) : 0;
    if (!fill) begin
      int tr = len;
      logic [31:0] ta = a;
      while (tr > 0) begin
        int room = 64 - int'(ta[5:0]);
        int t = (tr < room) ? tr : room;
        ta += 32'(t); tr -= t; total++;
      end
    end
    chk(req_ready == 1'b1, "R1", "req_ready when idle", req_ready, 1);
    req_addr = a; req_len = 12'(len); req_fill = fill; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk(done == 1'b1, "R9", "done after empty request", done, 1);
      chk(ar_valid == 1'b0, "R9", "no burst for empty request", ar_valid, 0);
      return;
    end
    while (np < total) begin
      logic [31:0] ea;
      int el, eb, stall, t, off;
      string tag;
      chk(done == 1'b0, "R8", "done low mid-request", done, 0);
      if (fill) begin
        ea = {ca[31:3], 3'b000}; el = 7; eb = 2; t = r; tag = "R2";
      end else begin
        off = int'(ca[5:0]);
        t = (r < 64 - off) ? r : 64 - off;
        ea = ca; el = ((off + t - 1) >> 3) - (off >> 3); eb = 1;
        tag = (total == 1) ? "R3" : (np == 0 ? "R4" : "R5");
      end
      stall = (np + int'(a[1:0]) + len) % 4;
      for (int k = 0; k < stall; k++) begin
        ar_ready = 1'b0;
        chk_fields((k == 0) ? tag : "R7", ea, el, eb);
        @(negedge clk);
      end
      chk_fields(tag, ea, el, eb);
      if (eb == 1)
        chk(int'(ar_addr[5:3]) + int'(ar_len) <= 7, "R6", "line crossing",
            int'(ar_addr[5:3]) + int'(ar_len), 7);
      ar_ready = 1'b1;
      @(negedge clk);
      ar_ready = 1'b0;
      ca += 32'(t); r -= t; np++;
    end
    chk(done == 1'b1, "R8", "done after final piece", done, 1);
    chk(ar_valid == 1'b0, "R8", "no burst after final piece", ar_valid, 0);
  endtask

  initial begin
    int lens[16] = '{1, 7, 8, 9, 31, 32, 33, 56, 63, 64, 65, 100, 128, 130, 200, 0};
    repeat (3) @(negedge clk);
    chk(ar_valid == 1'b0, "R1", "reset ar_valid", ar_valid, 0);
    chk(done == 1'b0, "R8", "reset done", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    for (int off = 0; off < 64; off++) begin
      for (int li = 0; li < 16; li++) begin
        run_req(32'h0000_1000 + 32'(li * 256) + 32'(off), lens[li], 1'b0);
      end
      run_req(32'h0008_0000 + 32'(off * 64) + 32'(off), 4 + off, 1'b1);
      run_req(32'h0009_0000 + 32'(off), 0, 1'b1);
    end
    run_req(32'h0000_2000, 4095, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule